// File: doc/BRIEF.md
# Dual-Request Interrupt Controller

This block gathers up to 32 interrupt sources, which may be asynchronous to the controller clock, and turns them into two active-high request lines and one wake line. Software chooses a trigger style for each source from three configuration bit planes. The choices are rising edge, falling edge, both edges, high level, low level or off. Each source also has a mask enable, a wake enable and a routing bit that picks one of the two request lines.

Every stored bit plane has two write addresses. A write to the set address turns on each bit given as 1. A write to the clear address turns off each bit given as 1. In both cases a 0 in the write data leaves that bit as it was, so software can change one source without a read-modify-write. Edge events are held in latches until software clears them, and rising and falling events are cleared separately. Software reads the pending bits for each request line through a status address.

Top module: `intc_dual_req`

## Requirements
- R1: After reset, every configuration plane, the mask, wake and source-select planes, both edge latches and the test bit read 0, and the routing plane reads all ones. req0_o, req1_o and wake_o are low.
- R2: The write addresses are: 0/1 cfg0 set/clear, 2/3 cfg1, 4/5 cfg2, 6/7 mask, 8/9 wake, 10/11 source-select, 12/13 routing. A write changes only the bits given as 1 in the data. The read addresses are: 0 cfg0, 1 cfg1, 2 cfg2, 3 mask, 4 wake, 5 source-select, 6 routing. Each returns the current value of that plane.
- R3: The trigger code is {cfg2,cfg1,cfg0} per source: 001 rising edge, 010 falling edge, 011 both edges, 101 high level, 110 low level. The codes 000, 100 and 111 never make the source pending.
- R4: In an edge mode, a detected edge sets a latch that stays set after the input returns. The rising latch reads at address 9 and the falling latch at address 10. An edge is latched only when the current mode enables that edge direction.
- R5: Writing 1s to address 14 clears those rising latches only. Writing 1s to address 15 clears those falling latches only.
- R6: A source reaches a request line only while its mask bit is 1. Clearing the mask leaves its edge latches unchanged.
- R7: Routing bit 1 sends a source to request line 0, and routing bit 0 sends it to line 1. Address 7 reads the pending bits for line 0 and address 8 the pending bits for line 1. Each shows only unmasked, pending sources routed to that line.
- R8: req0_o is high exactly when the address-7 status is nonzero. req1_o is high exactly when the address-8 status is nonzero.
- R9: wake_o is high when any source is pending and has its wake bit set, whatever its mask bit.
- R10: Each input passes through a two-flop synchroniser. A level-mode change on an input shows in the status two clock edges after it is driven, and not after one.
- R11: Address 16 writes a one-bit test register from data bit 0. Address 11 reads it back in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | N | Interrupt source inputs |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | N | Write data (bits given as 1 take effect) |
| rd_addr | input | AW | Read address |
| rd_data | output | N | Combinational read data |
| req0_o | output | 1 | Request line 0 |
| req1_o | output | 1 | Request line 1 |
| wake_o | output | 1 | Wake line |

## Verification
The random phase mixes three kinds of step. Set and clear writes land on random sparse bit patterns in every plane, which can produce any trigger code including the unused ones. Random input toggles create edges in both directions, and latch-clear writes arrive while both latches of a source may be set. Together these separate correct per-mode gating, routing and masking from mistakes in a single code or line. The directed cases cover the points random stimulus seldom hits in isolation:
- the two-edge synchroniser latency;
- clearing the rising latch of a both-edge source while its falling latch stays set;
- a masked source that still drives wake;
- the disabled and low-level codes.

// File: rtl/intc_dual_req.sv
module intc_dual_req #(
  parameter int N  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_i,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [N-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [N-1:0]  rd_data,
  output logic          req0_o,
  output logic          req1_o,
  output logic          wake_o
);
  localparam logic [AW-1:0] W_C0S = AW'(0),  W_C0C = AW'(1);
  localparam logic [AW-1:0] W_C1S = AW'(2),  W_C1C = AW'(3);
  localparam logic [AW-1:0] W_C2S = AW'(4),  W_C2C = AW'(5);
  localparam logic [AW-1:0] W_MKS = AW'(6),  W_MKC = AW'(7);
  localparam logic [AW-1:0] W_WKS = AW'(8),  W_WKC = AW'(9);
  localparam logic [AW-1:0] W_SLS = AW'(10), W_SLC = AW'(11);
  localparam logic [AW-1:0] W_RTS = AW'(12), W_RTC = AW'(13);
  localparam logic [AW-1:0] W_RLC = AW'(14), W_FLC = AW'(15);
  localparam logic [AW-1:0] W_TST = AW'(16);

  logic [N-1:0] cfg0, cfg1, cfg2, mask, wen, ssel, route;
  logic         tbit;
  logic [N-1:0] s1, s2, s3;
  logic [N-1:0] rise_lat, fall_lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg0 <= '0; cfg1 <= '0; cfg2 <= '0; mask <= '0;
      wen <= '0; ssel <= '0; route <= '1; tbit <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        W_C0S: cfg0  <= cfg0  |  wr_data;
        W_C0C: cfg0  <= cfg0  & ~wr_data;
        W_C1S: cfg1  <= cfg1  |  wr_data;
        W_C1C: cfg1  <= cfg1  & ~wr_data;
        W_C2S: cfg2  <= cfg2  |  wr_data;
        W_C2C: cfg2  <= cfg2  & ~wr_data;
        W_MKS: mask  <= mask  |  wr_data;
        W_MKC: mask  <= mask  & ~wr_data;
        W_WKS: wen   <= wen   |  wr_data;
        W_WKC: wen   <= wen   & ~wr_data;
        W_SLS: ssel  <= ssel  |  wr_data;
        W_SLC: ssel  <= ssel  & ~wr_data;
        W_RTS: route <= route |  wr_data;
        W_RTC: route <= route & ~wr_data;
        W_TST: tbit  <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= src_i; s2 <= s1; s3 <= s2;
    end
  end

  wire [N-1:0] rise_en  = ~cfg2 & cfg0;
  wire [N-1:0] fall_en  = ~cfg2 & cfg1;
  wire [N-1:0] hi_en    = cfg2 & ~cfg1 & cfg0;
  wire [N-1:0] lo_en    = cfg2 & cfg1 & ~cfg0;
  wire [N-1:0] rise_hit = s2 & ~s3 & rise_en;
  wire [N-1:0] fall_hit = ~s2 & s3 & fall_en;
  wire [N-1:0] rise_kill = (wr_en && wr_addr == W_RLC) ? wr_data : '0;
  wire [N-1:0] fall_kill = (wr_en && wr_addr == W_FLC) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_lat <= '0; fall_lat <= '0;
    end else begin
      rise_lat <= (rise_lat & ~rise_kill) | rise_hit;
      fall_lat <= (fall_lat & ~fall_kill) | fall_hit;
    end
  end

  wire [N-1:0] raw   = (rise_lat & rise_en) | (fall_lat & fall_en) | (hi_en & s2) | (lo_en & ~s2);
  wire [N-1:0] pend0 = raw & mask & route;
  wire [N-1:0] pend1 = raw & mask & ~route;

  assign req0_o = |pend0;
  assign req1_o = |pend1;
  assign wake_o = |(raw & wen);

  always_comb begin
    case (rd_addr)
      AW'(0):  rd_data = cfg0;
      AW'(1):  rd_data = cfg1;
      AW'(2):  rd_data = cfg2;
      AW'(3):  rd_data = mask;
      AW'(4):  rd_data = wen;
      AW'(5):  rd_data = ssel;
      AW'(6):  rd_data = route;
      AW'(7):  rd_data = pend0;
      AW'(8):  rd_data = pend1;
      AW'(9):  rd_data = rise_lat;
      AW'(10): rd_data = fall_lat;
      AW'(11): rd_data = {{(N-1){1'b0}}, tbit};
      default: rd_data = '0;
    endcase
  end

  AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == W_MKS) |=> ((mask & $past(mask)) == $past(mask))); // R2
  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == W_RLC) |=> ((rise_lat & $past(rise_lat)) == $past(rise_lat))); // R4
  AST_RISE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == W_RLC) |=> ((rise_lat & $past(wr_data) & ~$past(s2 & ~s3)) == '0)); // R5
  AST_FALL_SPARED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == W_RLC) |=> ((fall_lat & $past(fall_lat)) == $past(fall_lat))); // R5
  AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == W_MKC && wr_data == '1) |=> (!req0_o && !req1_o)); // R6
endmodule

// File: tb/test_intc_dual_req.sv
module test_intc_dual_req;
  localparam int CLK_P = 10;
  localparam int N = 32;
  localparam int AW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src_i = '0, wr_data = '0, rd_data;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic wr_en = 1'b0, req0_o, req1_o, wake_o;
  int total = 0, bad = 0;
  bit finished = 0;

  logic [N-1:0] m_c0, m_c1, m_c2, m_mk, m_wk, m_sl, m_rt, m_rl, m_fl, m_in;
  logic m_tb;

  always #(CLK_P/2) clk = ~clk;

  intc_dual_req #(.N(N), .AW(AW)) i_intc_dual_req (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o));

  function automatic logic [N-1:0] mode_mask(input logic [2:0] code);
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++)
      r[i] = ({m_c2[i], m_c1[i], m_c0[i]} == code);
    return r;
  endfunction

  function automatic logic [N-1:0] exp_raw();
    return (m_rl & (mode_mask(3'b001) | mode_mask(3'b011)))
         | (m_fl & (mode_mask(3'b010) | mode_mask(3'b011)))
         | (m_in & mode_mask(3'b101)) | (~m_in & mode_mask(3'b110));
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [N-1:0] d);
    rd_addr = AW'(a);
    #1 d = rd_data;
  endtask

  task automatic wr(input int a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      0: m_c0 |= d;  1: m_c0 &= ~d;  2: m_c1 |= d;  3: m_c1 &= ~d;
      4: m_c2 |= d;  5: m_c2 &= ~d;  6: m_mk |= d;  7: m_mk &= ~d;
      8: m_wk |= d;  9: m_wk &= ~d;  10: m_sl |= d; 11: m_sl &= ~d;
      12: m_rt |= d; 13: m_rt &= ~d; 14: m_rl &= ~d; 15: m_fl &= ~d;
      16: m_tb = d[0];
      default: ;
    endcase
  endtask

  task automatic drive(input logic [N-1:0] v);
    @(negedge clk);
    src_i = v;
    m_rl |= ~m_in & v & (mode_mask(3'b001) | mode_mask(3'b011));
    m_fl |= m_in & ~v & (mode_mask(3'b010) | mode_mask(3'b011));
    m_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all();
    logic [N-1:0] d, raw, p0, p1;
    raw = exp_raw();
    p0 = raw & m_mk & m_rt;
    p1 = raw & m_mk & ~m_rt;
    rd(7, d);  check("R7 pend0", d, p0);
    rd(8, d);  check("R7 pend1", d, p1);
    rd(9, d);  check("R4 rise latch", d, m_rl);
    rd(10, d); check("R4 fall latch", d, m_fl);
    check("R8 req0", N'(req0_o), N'(|p0));
    check("R8 req1", N'(req1_o), N'(|p1));
    check("R9 wake", N'(wake_o), N'(|(raw & m_wk)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] d;
    void'($urandom(32'd1234));
    m_c0 = '0; m_c1 = '0; m_c2 = '0; m_mk = '0; m_wk = '0; m_sl = '0;
    m_rt = '1; m_rl = '0; m_fl = '0; m_in = '0; m_tb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin rd(a, d); check("R1 plane zero", d, '0); end
    rd(6, d);  check("R1 route ones", d, '1);
    rd(9, d);  check("R1 rise latch", d, '0);
    rd(10, d); check("R1 fall latch", d, '0);
    rd(11, d); check("R1 test bit", d, '0);
    check("R1 outputs", N'({req0_o, req1_o, wake_o}), '0);

    // R2 set/clear semantics
    wr(0, 32'h0000_00F0); wr(1, 32'h0000_0030); wr(0, '0);
    rd(0, d); check("R2 cfg0 set/clr", d, 32'h0000_00C0);
    wr(1, '1);
    wr(10, 32'h8000_0001); rd(5, d); check("R2 srcsel", d, 32'h8000_0001);
    wr(11, 32'h8000_0000); rd(5, d); check("R2 srcsel clr", d, 32'h0000_0001);

    // R11 test bit
    wr(16, 32'h1); rd(11, d); check("R11 test set", d, 32'h1);
    wr(16, 32'h0); rd(11, d); check("R11 test clr", d, 32'h0);

    // R10 latency: bit0 high level, masked in, route line 0
    wr(0, 32'h1); wr(4, 32'h1); wr(6, 32'h1);
    @(negedge clk); src_i[0] = 1'b1;
    @(negedge clk); rd(7, d); check("R10 one edge", d, '0);
    @(negedge clk); rd(7, d); check("R10 two edges", d, 32'h1);
    m_in[0] = 1'b1;
    repeat (2) @(negedge clk);
    check_all();
    drive(m_in & ~32'h1);
    check_all();

    // R3/R5 bit1 both edges, route line 1, wake on
    wr(0, 32'h2); wr(2, 32'h2); wr(6, 32'h2); wr(13, 32'h2); wr(8, 32'h2);
    drive(m_in | 32'h2); drive(m_in & ~32'h2);
    rd(8, d); check("R3 both edges pending", d, 32'h2);
    wr(14, 32'h2);
    rd(9, d);  check("R5 rise cleared", d & 32'h2, '0);
    rd(10, d); check("R5 fall kept", d & 32'h2, 32'h2);
    check_all();
    // R6 mask off keeps latch, R9 wake still high
    wr(7, 32'h2);
    rd(10, d); check("R6 latch kept", d & 32'h2, 32'h2);
    check("R6 req1 low", N'(req1_o), '0);
    check("R9 wake unmasked", N'(wake_o), 32'h1);
    wr(15, 32'h2); check_all();

    // R3 low level and disabled code
    wr(2, 32'h4); wr(4, 32'h4); wr(6, 32'h4);
    check_all();
    rd(7, d); check("R3 low level idle", d & 32'h4, 32'h4);
    drive(m_in | 32'h8);
    rd(7, d); check("R3 disabled ignored", d & 32'h8, '0);
    check_all();

    // random phase
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 6) wr(int'($urandom_range(0, 13)), $urandom & $urandom);
      else if (op < 8) drive(m_in ^ ($urandom & $urandom));
      else wr(14 + int'($urandom_range(0, 1)), $urandom & $urandom);
      check_all();
      rd(int'($urandom_range(0, 6)), d);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule